// File: doc/BRIEF.md
# Predicated Vector OR Unit

This block runs one merging, predicated, element-wise bitwise OR on a scalable-vector register file. A 32-bit instruction word arrives with a valid strobe. The block compares it against a fixed opcode pattern and pulls out an element size, a governing predicate index and two vector register indices. It reads the register files and computes each element's result. The result goes back into the destination register, which is also the first source operand.

Each element is governed by a predicate register that holds one bit per byte of the vector. The decoded element size picks which predicate bit decides each element. Active elements receive the OR of both sources. Inactive elements keep their old destination value; they are never zeroed. The vector length is a parameter. Test write ports preload both register files, and a combinational read port exposes any vector register.

Top module: `pred_vor_unit`

## Requirements
- R1: A valid word executes only when bits 31:24 equal 8'h04, bits 21:19 equal 3'b011, bits 18:16 equal 3'b000 and bits 15:13 equal 3'b000.
- R2: A valid word that fails the R1 pattern leaves every register unchanged. It raises `illegalInst` for exactly the one cycle after the edge that sampled it.
- R3: When `instValid` is low, nothing is written and `illegalInst` stays low, whatever `instWord` holds.
- R4: Field positions are as follows. Bits 23:22 give the element size: 00 is 8-bit, 01 is 16-bit, 10 is 32-bit and 11 is 64-bit. Bits 12:10 select predicate P0..P7. Bits 9:5 select the second source vector, and bits 4:0 select the destination, which is also the first source.
- R5: An active element of the destination becomes its old value ORed with the same element of the second source.
- R6: An inactive element of the destination keeps its old value.
- R7: An element is active when the predicate bit of its lowest-numbered byte is 1. Predicate bits for the other bytes of that element have no effect.
- R8: When no element is active, the destination is left exactly as it was.
- R9: The result can be read on `vecRdData` right after the clock edge that sampled the instruction. The second source register is not modified unless it is the destination.
- R10: A synchronous active-low reset clears all 32 vector registers and all 16 predicate registers to zero, and drives `illegalInst` low.
- R11: The test ports write a vector or a predicate register on a clock edge. If an executing instruction and a test write target the same vector register on the same edge, the instruction result is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| instValid | input | 1 | Instruction word is valid this cycle |
| instWord | input | 32 | Instruction word |
| illegalInst | output | 1 | One-cycle pulse after a valid word that does not match |
| vecWrEn | input | 1 | Test write enable, vector file |
| vecWrIdx | input | 5 | Test write index, vector file |
| vecWrData | input | VL | Test write data, vector file |
| predWrEn | input | 1 | Test write enable, predicate file |
| predWrIdx | input | 4 | Test write index, predicate file |
| predWrData | input | VL/8 | Test write data, predicate file |
| vecRdIdx | input | 5 | Read index, vector file |
| vecRdData | output | VL | Combinational read data, vector file |

## Verification
The bench uses predicates whose set bits fall only on the upper bytes of wider elements. A design that ORs any bit of the element, or that uses byte lanes without regard to size, would then update elements that must stay put. Each of the four opcode sub-fields is broken one at a time. A partial decoder would execute those words instead of flagging them, and would corrupt the destination. A predicate cleared by reset, a destination that doubles as the second source, and a test write that collides with an execute write are each checked. A design that zeroed inactive elements, wrote the wrong register, or let the test write win would show a wrong destination value.

// File: rtl/pred_vor_pkg.sv
package pred_vor_pkg;
  localparam int NUM_VREG = 32;
  localparam int NUM_PREG = 16;
  localparam int VIDX_W   = $clog2(NUM_VREG);
  localparam int PIDX_W   = $clog2(NUM_PREG);

  // fixed opcode fields (R1)
  localparam logic [7:0] OPC_TOP = 8'h04;
  localparam logic [2:0] OPC_MID = 3'b011;
  localparam logic [2:0] OPC_LOW = 3'b000;
  localparam logic [2:0] OPC_PAD = 3'b000;

  typedef enum logic [1:0] {
    ESZ_B = 2'b00,
    ESZ_H = 2'b01,
    ESZ_S = 2'b10,
    ESZ_D = 2'b11
  } elemSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              wrEn;
    elemSize_e         esize;
    logic [2:0]        pg;
    logic [VIDX_W-1:0] zm;
    logic [VIDX_W-1:0] zdn;
  } ctlStrb_t;
endpackage

// File: rtl/pred_vor_ctrl.sv
module pred_vor_ctrl
  import pred_vor_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  input  logic [31:0] instWord,
  output ctlStrb_t    strb,
  output logic        illegalInst
);
  logic isMatch;
  logic illegalQ;

  always_comb begin
    isMatch = (instWord[31:24] == OPC_TOP) &&
              (instWord[21:19] == OPC_MID) &&
              (instWord[18:16] == OPC_LOW) &&
              (instWord[15:13] == OPC_PAD);
    strb.wrEn  = instValid && isMatch;
    strb.esize = elemSize_e'(instWord[23:22]);
    strb.pg    = instWord[12:10];
    strb.zm    = instWord[9:5];
    strb.zdn   = instWord[4:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) illegalQ <= 1'b0;
    else       illegalQ <= instValid && !isMatch;
  end

  assign illegalInst = illegalQ;

  // R2: a bad top byte on a valid word gives the pulse next cycle
  a_r2_illegal_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instWord[31:24] != OPC_TOP) |=> illegalInst);

  // R3: no valid word, no pulse
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> !illegalInst);

  // R1: a broken pattern never requests a write
  a_r1_no_write_bad_pattern: assert property (@(posedge clk) disable iff (!rstN)
    (instWord[21:19] != OPC_MID || instWord[15:13] != OPC_PAD) |-> !strb.wrEn);
endmodule

// File: rtl/pred_vor_dpath.sv
module pred_vor_dpath
  import pred_vor_pkg::*;
#(
  parameter int VL = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic              vecWrEn,
  input  logic [VIDX_W-1:0] vecWrIdx,
  input  logic [VL-1:0]     vecWrData,
  input  logic              predWrEn,
  input  logic [PIDX_W-1:0] predWrIdx,
  input  logic [VL/8-1:0]   predWrData,
  input  logic [VIDX_W-1:0] vecRdIdx,
  output logic [VL-1:0]     vecRdData
);
  localparam int PL = VL / 8;

  logic [VL-1:0] vregs [NUM_VREG];
  logic [PL-1:0] pregs [NUM_PREG];

  logic [VL-1:0] opA;
  logic [VL-1:0] opM;
  logic [PL-1:0] pmask;
  logic [PL-1:0] laneAct;
  logic [VL-1:0] result;

  assign opA   = vregs[strb.zdn];
  assign opM   = vregs[strb.zm];
  assign pmask = pregs[{1'b0, strb.pg}];

  // one byte lane each; activity comes from the element's lowest byte
  for (genvar b = 0; b < PL; b++) begin : g_lane
    localparam int BASE_H = b - (b % 2);
    localparam int BASE_S = b - (b % 4);
    localparam int BASE_D = b - (b % 8);
    always_comb begin
      unique case (strb.esize)
        ESZ_B:   laneAct[b] = pmask[b];
        ESZ_H:   laneAct[b] = pmask[BASE_H];
        ESZ_S:   laneAct[b] = pmask[BASE_S];
        default: laneAct[b] = pmask[BASE_D];
      endcase
    end
    assign result[8*b +: 8] = laneAct[b] ? (opA[8*b +: 8] | opM[8*b +: 8])
                                         : opA[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_VREG; i++) vregs[i] <= '0;
      for (int i = 0; i < NUM_PREG; i++) pregs[i] <= '0;
    end else begin
      if (predWrEn) pregs[predWrIdx] <= predWrData;
      if (vecWrEn)  vregs[vecWrIdx]  <= vecWrData;
      if (strb.wrEn) vregs[strb.zdn] <= result;   // execute wins (R11)
    end
  end

  assign vecRdData = vregs[vecRdIdx];

  // R5: the OR only ever adds bits to the destination
  a_r5_bits_kept: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> ((vregs[$past(strb.zdn)] & $past(opA)) == $past(opA)));

  // R8: empty predicate leaves the destination alone
  a_r8_empty_pred: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && pmask == '0) |=> (vregs[$past(strb.zdn)] == $past(opA)));

  // R9: second source untouched when distinct
  a_r9_zm_untouched: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.zm != strb.zdn && !(vecWrEn && vecWrIdx == strb.zm))
      |=> (vregs[$past(strb.zm)] == $past(opM)));

  // R11: a colliding test write loses to the execute write
  a_r11_exec_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && vecWrEn && vecWrIdx == strb.zdn && pmask == '0)
      |=> (vregs[$past(strb.zdn)] == $past(opA)));
endmodule

// File: rtl/pred_vor_unit.sv
module pred_vor_unit
  import pred_vor_pkg::*;
#(
  parameter int VL = 256
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            instValid,
  input  logic [31:0]     instWord,
  output logic            illegalInst,
  input  logic            vecWrEn,
  input  logic [4:0]      vecWrIdx,
  input  logic [VL-1:0]   vecWrData,
  input  logic            predWrEn,
  input  logic [3:0]      predWrIdx,
  input  logic [VL/8-1:0] predWrData,
  input  logic [4:0]      vecRdIdx,
  output logic [VL-1:0]   vecRdData
);
  ctlStrb_t strb;

  pred_vor_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .strb(strb), .illegalInst(illegalInst)
  );

  pred_vor_dpath #(.VL(VL)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .vecWrEn(vecWrEn), .vecWrIdx(vecWrIdx), .vecWrData(vecWrData),
    .predWrEn(predWrEn), .predWrIdx(predWrIdx), .predWrData(predWrData),
    .vecRdIdx(vecRdIdx), .vecRdData(vecRdData)
  );
endmodule

// File: tb/pred_vor_unit_test.sv
`timescale 1ns/1ps
module pred_vor_unit_test;
  localparam int VL = 256;
  localparam int PL = VL / 8;

  typedef struct packed {
    logic [1:0]  size;
    logic [2:0]  pg;
    logic [4:0]  zdn;
    logic [4:0]  zm;
    logic [31:0] pred;
    logic [31:0] seedA;
    logic [31:0] seedM;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 3'd0, 5'd1,  5'd2,  32'hFFFFFFFF, 32'h12345678, 32'h0F0F00F0},
    '{2'd0, 3'd3, 5'd3,  5'd4,  32'h5A5A1234, 32'h80000001, 32'hFFFF0000},
    '{2'd1, 3'd1, 5'd5,  5'd6,  32'h55555555, 32'h00FF00FF, 32'hA5A5A5A5},
    '{2'd1, 3'd2, 5'd7,  5'd8,  32'hAAAAAAAA, 32'h11111111, 32'hEEEEEEEE},
    '{2'd2, 3'd4, 5'd10, 5'd11, 32'h11110101, 32'h01020304, 32'hF0F0F0F0},
    '{2'd2, 3'd5, 5'd12, 5'd13, 32'hEEEEEEEE, 32'h00000000, 32'hFFFFFFFF},
    '{2'd3, 3'd7, 5'd14, 5'd31, 32'h00000101, 32'hC0C0C0C0, 32'h0303F00F},
    '{2'd3, 3'd6, 5'd0,  5'd15, 32'hFEFEFEFE, 32'h12121212, 32'h48484848},
    '{2'd2, 3'd0, 5'd9,  5'd9,  32'h0F0F0F0F, 32'hDEADBEEF, 32'hDEADBEEF}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic illegalInst;
  logic vecWrEn = 1'b0;
  logic [4:0] vecWrIdx = '0;
  logic [VL-1:0] vecWrData = '0;
  logic predWrEn = 1'b0;
  logic [3:0] predWrIdx = '0;
  logic [PL-1:0] predWrData = '0;
  logic [4:0] vecRdIdx = '0;
  logic [VL-1:0] vecRdData;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pred_vor_unit #(.VL(VL)) uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .illegalInst(illegalInst), .vecWrEn(vecWrEn), .vecWrIdx(vecWrIdx),
    .vecWrData(vecWrData), .predWrEn(predWrEn), .predWrIdx(predWrIdx),
    .predWrData(predWrData), .vecRdIdx(vecRdIdx), .vecRdData(vecRdData)
  );

  function automatic logic [31:0] mkWord(logic [1:0] sz, logic [2:0] pg,
                                         logic [4:0] zm, logic [4:0] zdn);
    return {8'h04, sz, 3'b011, 3'b000, 3'b000, pg, zm, zdn};
  endfunction

  function automatic logic [VL-1:0] fill(logic [31:0] seed);
    logic [VL-1:0] d;
    for (int w = 0; w < VL / 32; w++) d[32*w +: 32] = seed ^ (32'h01030507 * w);
    return d;
  endfunction

  // spec model: element active if the bit of its lowest byte is set
  function automatic logic [VL-1:0] model(logic [VL-1:0] a, logic [VL-1:0] m,
                                          logic [PL-1:0] p, logic [1:0] sz);
    logic [VL-1:0] r;
    int eb;
    eb = 1 << sz;
    for (int b = 0; b < PL; b++)
      r[8*b +: 8] = p[b - (b % eb)] ? (a[8*b +: 8] | m[8*b +: 8]) : a[8*b +: 8];
    return r;
  endfunction

  task automatic chkVec(string req, logic [VL-1:0] act, logic [VL-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkBit(string req, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic writeVec(logic [4:0] idx, logic [VL-1:0] d);
    @(negedge clk);
    vecWrEn = 1'b1; vecWrIdx = idx; vecWrData = d;
    @(negedge clk);
    vecWrEn = 1'b0;
  endtask

  task automatic writePred(logic [3:0] idx, logic [PL-1:0] d);
    @(negedge clk);
    predWrEn = 1'b1; predWrIdx = idx; predWrData = d;
    @(negedge clk);
    predWrEn = 1'b0;
  endtask

  // drive for one cycle; returns at the negedge after the sampling edge
  task automatic issue(logic v, logic [31:0] w);
    @(negedge clk);
    instValid = v; instWord = w;
    @(negedge clk);
    instValid = 1'b0; instWord = '0;
  endtask

  task automatic readVec(logic [4:0] idx, output logic [VL-1:0] d);
    vecRdIdx = idx;
    #0.5;
    d = vecRdData;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [VL-1:0] rd;
    logic [VL-1:0] a, m;
    logic [31:0] badW [4];

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10: reset state
    readVec(5'd0, rd);  chkVec("R10 vreg0 after reset", rd, '0);
    readVec(5'd31, rd); chkVec("R10 vreg31 after reset", rd, '0);
    chkBit("R10 illegal after reset", illegalInst, 1'b0);

    // table walk: R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      a = fill(TBL[i].seedA);
      m = fill(TBL[i].seedM);
      writeVec(TBL[i].zdn, a);
      if (TBL[i].zm != TBL[i].zdn) writeVec(TBL[i].zm, m);
      else m = a;
      writePred({1'b0, TBL[i].pg}, TBL[i].pred);
      issue(1'b1, mkWord(TBL[i].size, TBL[i].pg, TBL[i].zm, TBL[i].zdn));
      readVec(TBL[i].zdn, rd);
      chkVec($sformatf("R5 R6 R7 R8 vector %0d dest", i), rd,
             model(a, m, TBL[i].pred, TBL[i].size));
      readVec(TBL[i].zm, rd);
      chkVec($sformatf("R9 vector %0d second source", i), rd,
             (TBL[i].zm == TBL[i].zdn) ? model(a, m, TBL[i].pred, TBL[i].size) : m);
      chkBit($sformatf("R1 vector %0d no illegal", i), illegalInst, 1'b0);
    end

    // R2: each opcode sub-field broken in turn
    badW[0] = mkWord(2'd0, 3'd0, 5'd2, 5'd20) ^ 32'h0100_0000;
    badW[1] = mkWord(2'd0, 3'd0, 5'd2, 5'd20) ^ 32'h0010_0000;
    badW[2] = mkWord(2'd0, 3'd0, 5'd2, 5'd20) ^ 32'h0001_0000;
    badW[3] = mkWord(2'd0, 3'd0, 5'd2, 5'd20) ^ 32'h0000_2000;
    a = fill(32'h00000000);
    writeVec(5'd20, a);
    writeVec(5'd2, fill(32'hFFFFFFFF));
    writePred(4'd0, '1);
    for (int k = 0; k < 4; k++) begin
      issue(1'b1, badW[k]);
      chkBit($sformatf("R2 bad word %0d pulse", k), illegalInst, 1'b1);
      readVec(5'd20, rd);
      chkVec($sformatf("R2 bad word %0d dest kept", k), rd, a);
      @(negedge clk);
      chkBit($sformatf("R2 bad word %0d pulse ends", k), illegalInst, 1'b0);
    end

    // R3: matching word without valid
    issue(1'b0, mkWord(2'd0, 3'd0, 5'd2, 5'd20));
    readVec(5'd20, rd);
    chkVec("R3 no valid no write", rd, a);
    chkBit("R3 no valid no pulse", illegalInst, 1'b0);

    // R11: colliding test write loses to execute
    a = fill(32'h0000FFFF);
    m = fill(32'h00FF0000);
    writeVec(5'd21, a);
    writeVec(5'd22, m);
    writePred(4'd1, '1);
    @(negedge clk);
    instValid = 1'b1; instWord = mkWord(2'd0, 3'd1, 5'd22, 5'd21);
    vecWrEn = 1'b1; vecWrIdx = 5'd21; vecWrData = '0;
    @(negedge clk);
    instValid = 1'b0; vecWrEn = 1'b0;
    readVec(5'd21, rd);
    chkVec("R11 execute beats test write", rd, a | m);

    // R10: reset clears predicates too (execution under P1 changes nothing)
    writePred(4'd1, '1);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    readVec(5'd21, rd);
    chkVec("R10 vector cleared by reset", rd, '0);
    a = fill(32'h0F000000);
    writeVec(5'd21, a);
    writeVec(5'd22, fill(32'hFFFFFFFF));
    issue(1'b1, mkWord(2'd0, 3'd1, 5'd22, 5'd21));
    readVec(5'd21, rd);
    chkVec("R10 predicate cleared by reset", rd, a);

    finishRun();
  end
endmodule